// File: doc/BRIEF.md
# Run-time programmable AND-OR logic array

This block is a small programmable logic array whose whole personality lives in configuration registers. Dedicated inputs and the pad readings of its own output pins form the array inputs. Every product term is an AND of literals, and each array input offers both a true and a complemented literal. The product terms are summed by OR gates into the outputs. Each output then passes through a polarity XOR and gets a tri-state enable computed by a product term of its own.

Software or a loader writes one configuration row per cycle through a write-enable, address and data port. Between writes the path from the inputs to the outputs is purely combinational. Two sharing modes are offered. In the fixed-group mode each output owns a contiguous group of terms. In the shared mode an OR-plane mask per output picks any subset of all terms, so one term can serve several outputs.

Top module: `pla_array`

## Requirements
- R1: While reset is asserted and afterwards until the first write, every output enable is 0, every data term is open, the mode is fixed-group, every polarity bit is 0, and so every `out_drv` bit is 1.
- R2: A term row holds a 2-bit field for each array input k at bits [2k+1:2k]. Code 01 requires the input to be 1, code 10 requires it to be 0, and code 00 leaves it out. Array input k is `in_i[k]` for k < N_IN and `pad_i[k-N_IN]` above that.
- R3: A term whose fields are all 00 evaluates to 1 for every input pattern.
- R4: A term with code 11 in any field evaluates to 0 for every input pattern.
- R5: With the mode bit 0 (fixed-group), output j is the OR of terms j*GROUP to j*GROUP+GROUP-1, and the OR-plane rows have no effect.
- R6: With the mode bit 1 (shared), output j is the OR of the terms whose bits are set in OR-plane row j, and one term may feed several outputs.
- R7: `out_drv[j]` is the OR result XOR polarity bit j.
- R8: `out_en[j]` equals enable term j. An enable row of all 11 fields holds the output disabled, and an all-00 row holds it enabled.
- R9: The pad reading `pad_i[j]` enters the AND plane whether or not output j is enabled.
- R10: A write with `cfg_we` high changes the outputs from the cycle after that clock edge, and with `cfg_we` low nothing changes. The map is: term rows 0..N_TERMS-1, then N_OUT enable rows, then N_OUT OR-plane rows (bit t = term t), then a control row with polarity in bits [N_OUT-1:0] and the mode in bit N_OUT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | ADDR_W (4) | Configuration row address |
| cfg_wdata | input | CFG_W (14) | Configuration row data |
| in_i | input | N_IN (4) | Dedicated array inputs |
| pad_i | input | N_OUT (3) | Pad readings of the output pins, fed back into the array |
| out_drv | output | N_OUT (3) | Value driven onto each output pin |
| out_en | output | N_OUT (3) | Tri-state enable of each output pin |

## Verification
Every personality is swept over all 128 combinations of the four dedicated inputs and three pad readings. The outputs and enables are compared with an arithmetic model of the array that the bench keeps. Single-literal personalities are tried on each input in true and complement form, which separates literal polarity and input ordering, pad inputs included. Open and contradictory terms show that the constant-1 and constant-0 rules hold. The same terms run under both sharing modes with different OR masks and polarities, which tells group ownership apart from mask selection and shows that a term shared by two outputs reaches both. Write timing is sampled on both sides of the clock edge, and a write with the enable low is checked to leave the outputs unchanged.

// File: rtl/pla_pkg.sv
package pla_pkg;
  typedef enum logic {
    SHARE_GROUP = 1'b0,
    SHARE_MASK  = 1'b1
  } share_mode_e;

  localparam logic [1:0] LIT_OPEN = 2'b00;
  localparam logic [1:0] LIT_TRUE = 2'b01;
  localparam logic [1:0] LIT_COMP = 2'b10;
  localparam logic [1:0] LIT_BOTH = 2'b11;
endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store
  import pla_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3,
  parameter int GROUP = 3,
  localparam int N_ARR   = N_IN + N_OUT,
  localparam int LIT_W   = 2 * N_ARR,
  localparam int N_TERMS = N_OUT * GROUP,
  localparam int N_ROWS  = N_TERMS + 2 * N_OUT + 1,
  localparam int ADDR_W  = $clog2(N_ROWS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [LIT_W-1:0]                  wdata,
  output logic [N_TERMS-1:0][LIT_W-1:0]     term_rows,
  output logic [N_OUT-1:0][LIT_W-1:0]       en_rows,
  output logic [N_OUT-1:0][N_TERMS-1:0]     or_rows,
  output logic [N_OUT-1:0]                  pol,
  output share_mode_e                       mode
);
  localparam int EN_BASE   = N_TERMS;
  localparam int OR_BASE   = N_TERMS + N_OUT;
  localparam int CTRL_ADDR = N_TERMS + 2 * N_OUT;

  logic [N_TERMS-1:0][LIT_W-1:0] term_q, term_nxt;
  logic [N_OUT-1:0][LIT_W-1:0]   en_q, en_nxt;
  logic [N_OUT-1:0][N_TERMS-1:0] or_q, or_nxt;
  logic [N_OUT-1:0]              pol_q, pol_nxt;
  share_mode_e                   mode_q, mode_nxt;

  // Next-state: decode the row address and replace exactly one row.
  always_comb begin
    term_nxt = term_q;
    en_nxt   = en_q;
    or_nxt   = or_q;
    pol_nxt  = pol_q;
    mode_nxt = mode_q;
    for (int i = 0; i < N_TERMS; i++) begin
      if (addr == ADDR_W'(i)) term_nxt[i] = wdata;
    end
    for (int j = 0; j < N_OUT; j++) begin
      if (addr == ADDR_W'(EN_BASE + j)) en_nxt[j] = wdata;
      if (addr == ADDR_W'(OR_BASE + j)) or_nxt[j] = wdata[N_TERMS-1:0];
    end
    if (addr == ADDR_W'(CTRL_ADDR)) begin
      pol_nxt  = wdata[N_OUT-1:0];
      mode_nxt = share_mode_e'(wdata[N_OUT]);
    end
  end

  // Registers: data terms open, enable terms contradictory (outputs off).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_q <= '0;
      en_q   <= '1;
      or_q   <= '0;
      pol_q  <= '0;
      mode_q <= SHARE_GROUP;
    end else if (we) begin
      term_q <= term_nxt;
      en_q   <= en_nxt;
      or_q   <= or_nxt;
      pol_q  <= pol_nxt;
      mode_q <= mode_nxt;
    end
  end

  assign term_rows = term_q;
  assign en_rows   = en_q;
  assign or_rows   = or_q;
  assign pol       = pol_q;
  assign mode      = mode_q;

  // R10: an idle port leaves every configuration row untouched.
  p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(term_q) && $stable(en_q) && $stable(or_q)
             && $stable(pol_q) && $stable(mode_q)));

  genvar gi;
  generate
    for (gi = 0; gi < N_TERMS; gi++) begin : g_term_chk
      // R10: a write to term row gi is visible after the edge.
      p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(gi)) |=> term_q[gi] == $past(wdata));
    end
  endgenerate
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_ARR = 7,
  parameter int N_ROW = 12,
  localparam int LIT_W = 2 * N_ARR
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_ARR-1:0]              arr_in,
  input  logic [N_ROW-1:0][LIT_W-1:0]   rows,
  output logic [N_ROW-1:0]              terms
);
  localparam logic [LIT_W-1:0] EVEN_MASK = {N_ARR{2'b01}};

  genvar gr, gk;
  generate
    for (gr = 0; gr < N_ROW; gr++) begin : g_row
      logic [N_ARR-1:0] lit_ok;
      for (gk = 0; gk < N_ARR; gk++) begin : g_lit
        // A connected true literal needs a 1, a connected complement a 0.
        assign lit_ok[gk] = !(rows[gr][2*gk]   && !arr_in[gk])
                         && !(rows[gr][2*gk+1] &&  arr_in[gk]);
      end
      assign terms[gr] = &lit_ok;

      // R3: an unconnected term is a constant 1.
      p_open_term_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rows[gr] == '0) |-> terms[gr]);
      // R4: a term holding both literals of one input is a constant 0.
      p_both_literals_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((rows[gr] & (rows[gr] >> 1) & EVEN_MASK) != '0) |-> !terms[gr]);
    end
  endgenerate
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane
  import pla_pkg::*;
#(
  parameter int N_OUT = 3,
  parameter int GROUP = 3,
  localparam int N_TERMS = N_OUT * GROUP
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_TERMS-1:0]            terms,
  input  logic [N_OUT-1:0][N_TERMS-1:0] or_rows,
  input  share_mode_e                   mode,
  input  logic [N_OUT-1:0]              pol,
  output logic [N_OUT-1:0]              drv
);
  genvar gj;
  generate
    for (gj = 0; gj < N_OUT; gj++) begin : g_out
      logic grp_sum, mask_sum, sum;
      assign grp_sum  = |terms[gj*GROUP +: GROUP];
      assign mask_sum = |(terms & or_rows[gj]);
      assign sum      = (mode == SHARE_MASK) ? mask_sum : grp_sum;
      assign drv[gj]  = sum ^ pol[gj];

      // R5: in group mode an all-zero group yields just the polarity bit.
      p_group_owns_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SHARE_GROUP && terms[gj*GROUP +: GROUP] == '0)
          |-> drv[gj] == pol[gj]);
    end
  endgenerate
endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3,
  parameter int GROUP = 3,
  localparam int N_ARR   = N_IN + N_OUT,
  localparam int CFG_W   = 2 * N_ARR,
  localparam int N_TERMS = N_OUT * GROUP,
  localparam int N_ROWS  = N_TERMS + 2 * N_OUT + 1,
  localparam int ADDR_W  = $clog2(N_ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [N_IN-1:0]   in_i,
  input  logic [N_OUT-1:0]  pad_i,
  output logic [N_OUT-1:0]  out_drv,
  output logic [N_OUT-1:0]  out_en
);
  logic rst_meta_n, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [N_TERMS-1:0][CFG_W-1:0]       term_rows;
  logic [N_OUT-1:0][CFG_W-1:0]         en_rows;
  logic [N_OUT-1:0][N_TERMS-1:0]       or_rows;
  logic [N_OUT-1:0]                    pol;
  share_mode_e                         mode;
  logic [N_TERMS+N_OUT-1:0][CFG_W-1:0] all_rows;
  logic [N_TERMS+N_OUT-1:0]            all_terms;
  logic [N_ARR-1:0]                    arr_in;

  pla_cfg_store #(.N_IN(N_IN), .N_OUT(N_OUT), .GROUP(GROUP)) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .term_rows (term_rows),
    .en_rows   (en_rows),
    .or_rows   (or_rows),
    .pol       (pol),
    .mode      (mode)
  );

  // Pad readings join the dedicated inputs regardless of the enables.
  assign arr_in   = {pad_i, in_i};
  assign all_rows = {en_rows, term_rows};

  pla_and_plane #(.N_ARR(N_ARR), .N_ROW(N_TERMS + N_OUT)) u_and (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .arr_in (arr_in),
    .rows   (all_rows),
    .terms  (all_terms)
  );

  pla_or_plane #(.N_OUT(N_OUT), .GROUP(GROUP)) u_or (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .terms   (all_terms[N_TERMS-1:0]),
    .or_rows (or_rows),
    .mode    (mode),
    .pol     (pol),
    .drv     (out_drv)
  );

  assign out_en = all_terms[N_TERMS +: N_OUT];
endmodule

// File: tb/pla_array_tb.sv
`timescale 1ns/1ps
module pla_array_tb;
  localparam int N_IN = 4, N_OUT = 3, GROUP = 3;
  localparam int N_ARR = N_IN + N_OUT, W = 2 * N_ARR, NT = N_OUT * GROUP;
  localparam int EN_B = NT, OR_B = NT + N_OUT, CTRL = NT + 2 * N_OUT;

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [W-1:0] cfg_wdata = '0;
  logic [N_IN-1:0] in_i = '0;
  logic [N_OUT-1:0] pad_i = '0;
  logic [N_OUT-1:0] out_drv, out_en;
  int checks = 0, fails = 0, cyc = 0;

  logic [W-1:0] sh_term [NT];
  logic [W-1:0] sh_en [N_OUT];
  logic [NT-1:0] sh_or [N_OUT];
  logic [N_OUT:0] sh_ctrl;

  always #2.5 clk = ~clk;

  pla_array u_dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_i(in_i), .pad_i(pad_i), .out_drv(out_drv), .out_en(out_en));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [W-1:0] lit(int k, logic [1:0] code);
    logic [W-1:0] r = '0;
    r[2*k +: 2] = code;
    return r;
  endfunction

  function automatic logic eval_row(logic [W-1:0] row, logic [N_ARR-1:0] x);
    logic r = 1'b1;
    for (int k = 0; k < N_ARR; k++) begin
      if (row[2*k +: 2] == 2'b11) r = 1'b0;
      if (row[2*k +: 2] == 2'b01 && !x[k]) r = 1'b0;
      if (row[2*k +: 2] == 2'b10 && x[k]) r = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [N_OUT-1:0] exp_drv(logic [N_ARR-1:0] x);
    logic [N_OUT-1:0] d;
    for (int j = 0; j < N_OUT; j++) begin
      logic s = 1'b0;
      for (int t = 0; t < NT; t++) begin
        if (sh_ctrl[N_OUT] ? sh_or[j][t] : (t / GROUP == j)) s = s | eval_row(sh_term[t], x);
      end
      d[j] = s ^ sh_ctrl[j];
    end
    return d;
  endfunction

  function automatic logic [N_OUT-1:0] exp_en(logic [N_ARR-1:0] x);
    logic [N_OUT-1:0] e;
    for (int j = 0; j < N_OUT; j++) e[j] = eval_row(sh_en[j], x);
    return e;
  endfunction

  task automatic check(string tag, logic [N_OUT-1:0] got, logic [N_OUT-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic wr(int a, logic [W-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < NT) sh_term[a] = d;
    else if (a < OR_B) sh_en[a - EN_B] = d;
    else if (a < CTRL) sh_or[a - OR_B] = d[NT-1:0];
    else sh_ctrl = d[N_OUT:0];
  endtask

  task automatic sweep(string tag);
    for (int x = 0; x < (1 << N_ARR); x++) begin
      @(negedge clk);
      in_i = x[N_IN-1:0]; pad_i = x[N_ARR-1:N_IN];
      #1;
      check(tag, out_drv, exp_drv(N_ARR'(x)));
      check({tag, " R8 enable"}, out_en, exp_en(N_ARR'(x)));
    end
  endtask

  initial begin
    for (int t = 0; t < NT; t++) sh_term[t] = '0;
    for (int j = 0; j < N_OUT; j++) begin sh_en[j] = '1; sh_or[j] = '0; end
    sh_ctrl = '0;
    #12;
    check("R1 enables in reset", out_en, 3'b000);
    check("R1 drive in reset", out_drv, 3'b111);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 enables after reset", out_en, 3'b000);
    check("R1 drive after reset", out_drv, 3'b111);

    // R2: single literal on each array input, both polarities, pads included
    wr(1, lit(0, 2'b11));
    wr(2, lit(0, 2'b11));
    for (int k = 0; k < N_ARR; k++) begin
      wr(0, lit(k, 2'b01)); sweep("R2 true literal R9");
      wr(0, lit(k, 2'b10)); sweep("R2 complement literal R9");
    end

    // R3 and R4: open and contradictory terms
    wr(0, lit(0, 2'b11)); wr(1, lit(3, 2'b11) | lit(1, 2'b01)); wr(2, lit(6, 2'b11));
    wr(EN_B + 0, '0); wr(EN_B + 2, lit(5, 2'b11));
    sweep("R3 R4 constant terms");

    // R5 R7 R9: group mode, junk OR rows, mixed polarity, pad feedback
    wr(0, lit(0, 2'b01) | lit(1, 2'b10));
    wr(1, lit(0, 2'b10) | lit(1, 2'b01));
    wr(2, lit(2, 2'b11));
    wr(3, lit(2, 2'b01) | lit(4, 2'b01));
    wr(4, lit(0, 2'b11));
    wr(5, lit(3, 2'b10) | lit(6, 2'b01));
    wr(6, lit(5, 2'b01));
    wr(7, lit(0, 2'b01) | lit(1, 2'b01) | lit(2, 2'b01) | lit(3, 2'b01));
    wr(8, lit(4, 2'b11));
    wr(EN_B + 0, '0); wr(EN_B + 1, '1); wr(EN_B + 2, lit(3, 2'b01));
    wr(OR_B + 0, 14'h1FF); wr(OR_B + 1, 14'h0AA); wr(OR_B + 2, 14'h001);
    wr(CTRL, 14'b0010);
    sweep("R5 R7 R9 group mode");

    // R6: shared mode with term 0 feeding two outputs
    wr(OR_B + 0, 14'b001000011);
    wr(OR_B + 1, 14'b010000001);
    wr(OR_B + 2, 14'b000101000);
    wr(EN_B + 0, lit(0, 2'b01) | lit(0, 2'b10)); wr(EN_B + 1, lit(4, 2'b10));
    wr(CTRL, 14'b1100);
    sweep("R6 shared mode");
    wr(CTRL, 14'b1111);
    sweep("R6 R7 inverted polarity");

    // R10: write timing around the edge, then an idle port
    wr(CTRL, 14'b0000);
    wr(0, lit(0, 2'b11)); wr(1, lit(0, 2'b11)); wr(2, lit(0, 2'b11));
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = '0;
    #1 check("R10 before edge", {2'b00, out_drv[0]}, 3'b000);
    @(posedge clk); #1;
    check("R10 after edge", {2'b00, out_drv[0]}, 3'b001);
    sh_term[0] = '0;
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = 4'd0; cfg_wdata = lit(0, 2'b11);
    repeat (2) @(negedge clk);
    cfg_addr = 4'(CTRL); cfg_wdata = 14'b1111;
    repeat (2) @(negedge clk);
    sweep("R10 idle port no effect");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule